// File: doc/BRIEF.md
# MDIO Management Bus Master

This block is a register-programmed master for the two-wire PHY management bus (MDC clock, bidirectional MDIO data). It carries out Clause 22 register reads and writes for a host. The host sees two 32-bit registers through a simple memory-mapped port. A command register at byte offset 0x0 holds the operation, the PHY and register addresses, the MDC divider code, a reset control and a self-clearing busy flag. A data register at offset 0x4 holds the 16-bit value to send, or the value received.

To write a PHY register, software loads the data register and then writes the command register with the write and busy bits set. To read one, it writes the command register with busy set and write clear. In both cases it polls busy until it returns to 0; after a read, the data register then holds the result. MDC is derived from the system clock through a coded divider, and each transaction sends one 64-bit frame. The MDIO pad is split into output, output-enable and input signals.

Top module: `mdio_master`

## Requirements
- R1: After reset, both registers read 0, MDC is low, MDIO output-enable is low and MDIO output is 0.
- R2: Command register (offset 0x0) fields: bit 0 busy/start, bit 1 operation (1 write, 0 read), bit 2 reset command, bits 10:4 register address, bits 16:12 PHY address, bits 22:20 divider code. Every other bit reads 0. The data register (offset 0x4) reads its 16-bit value in bits 15:0 and 0 above. A command write with bits 0 and 2 clear only updates the fields.
- R3: The divider code selects the system-clock cycles per MDC period: 000→42, 001→62, 010→16, 011→26, 100→102, 101→124. Busy reads 1 for exactly 64 MDC periods after the start write and then clears by itself.
- R4: Reserved divider codes 110 and 111 act as ratio 124.
- R5: MDC stays low while no frame is running. Each high phase and each low phase lasts half the selected ratio.
- R6: A write frame sends, MSB first: 32 ones, 01, opcode 01, the 5-bit PHY address, the low 5 bits of the register field, turnaround 10, and the 16 data bits. Output-enable is high for all 64 bits.
- R7: A read frame sends 32 ones, 01, opcode 10, the PHY address and the low 5 register bits. It then holds output-enable low for the 2 turnaround bits and the 16 data bits. The data bits are sampled MSB first on MDC rising edges and written to the data register when busy clears.
- R8: MDIO output and output-enable change only when MDC falls, never while MDC is high.
- R9: Writes to either register while busy is 1 have no effect, including a second start.
- R10: A command write with bit 2 set starts a reset: the data register is cleared and busy reads 1 for RST_CYC cycles (default 4). No MDC edge occurs, and the reset takes precedence over bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Host access strobe |
| bus_wr | input | 1 | Host access is a write |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Register read data (combinational on bus_addr) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value driven to the pad |
| mdio_oe | output | 1 | MDIO pad output-enable |
| mdio_i | input | 1 | MDIO value seen at the pad |

## Verification
The assertions check four properties on every cycle. MDC is low whenever busy is clear. MDIO output and enable are frozen during every MDC high phase. The enable is low when idle. The latched command never moves while a transaction is active. The checker also bounds each MDC high phase by the largest half ratio. Only the bench scenarios can show the behaviour that needs a PHY model and a reference: the exact busy length for every divider code, including the reserved fallback; bit-exact frame contents; sampled read data reaching the data register; the precedence of a reset over a start; and that writes made while busy leave both the registers and the frame in flight unchanged.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_LEN = 64;
  localparam int DATA_W    = 16;
  localparam int PHY_W     = 5;
  localparam int REGF_W    = 7;
  localparam int REGS_W    = 5;   // register bits carried in a frame
  localparam int DIV_W     = 3;
  localparam int HALF_W    = 6;

  // command register bit positions (host visible)
  localparam int BUSY_B  = 0;
  localparam int WR_B    = 1;
  localparam int RST_B   = 2;
  localparam int REG_LSB = 4;
  localparam int PHY_LSB = 12;
  localparam int DIV_LSB = 20;

  typedef struct packed {
    logic [DIV_W-1:0]  div;
    logic [PHY_W-1:0]  phy;
    logic [REGF_W-1:0] regf;
    logic              wr;
  } cmd_t;

  // half of the MDC ratio for each divider code; reserved codes use the slowest
  function automatic logic [HALF_W-1:0] half_period(input logic [DIV_W-1:0] code);
    case (code)
      3'd0:    half_period = 6'd21;
      3'd1:    half_period = 6'd31;
      3'd2:    half_period = 6'd8;
      3'd3:    half_period = 6'd13;
      3'd4:    half_period = 6'd51;
      default: half_period = 6'd62;
    endcase
  endfunction
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int HW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [HW-1:0] half,
  output logic          mdc,
  output logic          rise_evt,
  output logic          fall_evt
);
  logic [HW-1:0] cnt_q, cnt_d;
  logic          mdc_q, mdc_d;
  logic          wrap;

  assign wrap     = run && (cnt_q == (half - 1'b1));
  assign rise_evt = wrap & ~mdc_q;
  assign fall_evt = wrap & mdc_q;
  assign mdc      = mdc_q;

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (wrap) begin
      cnt_d = '0;
      mdc_d = ~mdc_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              wr_i,
  input  logic [PHY_W-1:0]  phy_i,
  input  logic [REGS_W-1:0] regf_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rise_evt,
  input  logic              fall_evt,
  input  logic              mdio_i,
  output logic              active,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              done,
  output logic [DATA_W-1:0] rdata
);
  localparam int CNT_W     = $clog2(FRAME_LEN);
  localparam int PRE_LEN   = FRAME_LEN - (2 + 2 + PHY_W + REGS_W + 2 + DATA_W);
  localparam int RX_FIRST  = FRAME_LEN - DATA_W;
  localparam int TA_FIRST  = RX_FIRST - 2;
  localparam logic [CNT_W-1:0] RX_IDX   = CNT_W'(RX_FIRST);
  localparam logic [CNT_W-1:0] TA_IDX   = CNT_W'(TA_FIRST);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_LEN - 1);

  logic                 active_q, active_d;
  logic                 wr_q, wr_d;
  logic [CNT_W-1:0]     bit_q, bit_d;
  logic [FRAME_LEN-1:0] sr_q, sr_d;
  logic [DATA_W-1:0]    rx_q, rx_d;
  logic                 last;

  assign last    = (bit_q == LAST_IDX);
  assign done    = active_q & fall_evt & last;
  assign active  = active_q;
  assign mdio_o  = active_q & sr_q[FRAME_LEN-1];
  assign mdio_oe = active_q & (wr_q | (bit_q < TA_IDX));
  assign rdata   = rx_q;

  always_comb begin
    active_d = active_q;
    wr_d     = wr_q;
    bit_d    = bit_q;
    sr_d     = sr_q;
    rx_d     = rx_q;
    if (start) begin
      active_d = 1'b1;
      wr_d     = wr_i;
      bit_d    = '0;
      rx_d     = '0;
      sr_d     = {{PRE_LEN{1'b1}}, 2'b01,
                  (wr_i ? 2'b01 : 2'b10),
                  phy_i, regf_i,
                  (wr_i ? 2'b10 : 2'b00),
                  (wr_i ? wdata_i : {DATA_W{1'b0}})};
    end else if (active_q) begin
      if (rise_evt && !wr_q && (bit_q >= RX_IDX))
        rx_d = {rx_q[DATA_W-2:0], mdio_i};
      if (fall_evt) begin
        if (last) begin
          active_d = 1'b0;
        end else begin
          bit_d = bit_q + 1'b1;
          sr_d  = {sr_q[FRAME_LEN-2:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      wr_q     <= 1'b0;
      bit_q    <= '0;
      sr_q     <= '0;
      rx_q     <= '0;
    end else begin
      active_q <= active_d;
      wr_q     <= wr_d;
      bit_q    <= bit_d;
      sr_q     <= sr_d;
      rx_q     <= rx_d;
    end
  end
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_pkg::*;
#(
  parameter int ADDR_W  = 3,
  parameter int RST_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              frame_done,
  input  logic [DATA_W-1:0] frame_rdata,
  output logic              busy,
  output logic              start,
  output cmd_t              cmd_q,
  output logic [DATA_W-1:0] data_q
);
  localparam int RCW = $clog2(RST_CYC + 1);
  localparam logic [ADDR_W-1:0] OFS_CMD  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFS_DATA = ADDR_W'(4);

  cmd_t              cmd_d;
  logic [DATA_W-1:0] data_d;
  logic              busy_q, busy_d;
  logic              ract_q, ract_d;
  logic [RCW-1:0]    rcnt_q, rcnt_d;
  logic              cmd_wr, data_wr, rst_req;
  logic              unused_wdata;

  assign cmd_wr  = bus_en & bus_wr & (bus_addr == OFS_CMD)  & ~busy_q;
  assign data_wr = bus_en & bus_wr & (bus_addr == OFS_DATA) & ~busy_q;
  assign rst_req = cmd_wr & bus_wdata[RST_B];
  assign start   = cmd_wr & bus_wdata[BUSY_B] & ~bus_wdata[RST_B];
  assign busy    = busy_q;
  assign unused_wdata = ^{bus_wdata[31:23], bus_wdata[19:17], bus_wdata[11], bus_wdata[3]};

  always_comb begin
    cmd_d  = cmd_q;
    data_d = data_q;
    busy_d = busy_q;
    ract_d = ract_q;
    rcnt_d = rcnt_q;
    if (rst_req) begin
      busy_d = 1'b1;
      ract_d = 1'b1;
      rcnt_d = RCW'(RST_CYC - 1);
      data_d = '0;
    end else if (cmd_wr) begin
      cmd_d.div  = bus_wdata[DIV_LSB +: DIV_W];
      cmd_d.phy  = bus_wdata[PHY_LSB +: PHY_W];
      cmd_d.regf = bus_wdata[REG_LSB +: REGF_W];
      cmd_d.wr   = bus_wdata[WR_B];
      if (start) busy_d = 1'b1;
    end
    if (data_wr) data_d = bus_wdata[DATA_W-1:0];
    if (ract_q) begin
      if (rcnt_q == '0) begin
        busy_d = 1'b0;
        ract_d = 1'b0;
      end else begin
        rcnt_d = rcnt_q - 1'b1;
      end
    end
    if (frame_done) begin
      busy_d = 1'b0;
      if (!cmd_q.wr) data_d = frame_rdata;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == OFS_CMD) begin
      bus_rdata[BUSY_B]                = busy_q;
      bus_rdata[WR_B]                  = cmd_q.wr;
      bus_rdata[REG_LSB +: REGF_W]     = cmd_q.regf;
      bus_rdata[PHY_LSB +: PHY_W]      = cmd_q.phy;
      bus_rdata[DIV_LSB +: DIV_W]      = cmd_q.div;
    end else if (bus_addr == OFS_DATA) begin
      bus_rdata[DATA_W-1:0] = data_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      data_q <= '0;
      busy_q <= 1'b0;
      ract_q <= 1'b0;
      rcnt_q <= '0;
    end else begin
      cmd_q  <= cmd_d;
      data_q <= data_d;
      busy_q <= busy_d;
      ract_q <= ract_d;
      rcnt_q <= rcnt_d;
    end
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int ADDR_W  = 3,
  parameter int RST_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  cmd_t              cmd_q;
  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] frame_rdata;
  logic              busy, start, frame_done, frame_active;
  logic              rise_evt, fall_evt;

  mdio_regs #(.ADDR_W(ADDR_W), .RST_CYC(RST_CYC)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_en(bus_en), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .frame_done(frame_done), .frame_rdata(frame_rdata),
    .busy(busy), .start(start), .cmd_q(cmd_q), .data_q(data_q)
  );

  mdio_mdc_gen #(.HW(HALF_W)) u_mdc (
    .clk(clk), .rst_n(rst_n), .run(frame_active),
    .half(half_period(cmd_q.div)),
    .mdc(mdc), .rise_evt(rise_evt), .fall_evt(fall_evt)
  );

  mdio_frame u_frame (
    .clk(clk), .rst_n(rst_n), .start(start),
    .wr_i(bus_wdata[WR_B]),
    .phy_i(bus_wdata[PHY_LSB +: PHY_W]),
    .regf_i(bus_wdata[REG_LSB +: REGS_W]),
    .wdata_i(data_q),
    .rise_evt(rise_evt), .fall_evt(fall_evt), .mdio_i(mdio_i),
    .active(frame_active), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .done(frame_done), .rdata(frame_rdata)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
  parameter int MAX_HALF = 62
) (
  input logic        clk,
  input logic        rst_n,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic        busy,
  input logic [15:0] cmd_q
);
  logic [7:0] hi_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                hi_run <= '0;
    else if (!mdc)             hi_run <= '0;
    else if (hi_run != 8'hFF)  hi_run <= hi_run + 1'b1;
  end

  a_r5_mdc_low_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);

  a_r5_high_phase_bound: assert property (@(posedge clk) disable iff (!rst_n)
    mdc |-> (hi_run < 8'(MAX_HALF)));

  a_r8_frozen_when_high: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

  a_r7_released_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe);

  a_r9_cmd_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cmd_q));
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_o(mdio_o),
  .mdio_oe(mdio_oe), .busy(busy), .cmd_q(cmd_q)
);

// File: tb/sim_mdio_master.sv
module sim_mdio_master;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic        clk, rst_n;
  logic        bus_en, bus_wr;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  logic [15:0] phy_val;
  logic [5:0]  nf;
  logic [63:0] cap, oecap;

  mdio_master u0 (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // PHY model: counts MDC falls (frame bit index), drives read data, captures bits
  always @(negedge mdc or negedge rst_n) begin
    if (!rst_n) nf <= '0;
    else        nf <= nf + 1'b1;
  end
  assign mdio_i = (nf >= 6'd48) ? phy_val[4'(6'd63 - nf)] : 1'b1;

  always @(posedge mdc) begin
    cap   <= {cap[62:0], mdio_o};
    oecap <= {oecap[62:0], mdio_oe};
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_ratio(input logic [2:0] code);
    case (code)
      3'd0: return 42;
      3'd1: return 62;
      3'd2: return 16;
      3'd3: return 26;
      3'd4: return 102;
      default: return 124;
    endcase
  endfunction

  function automatic logic [63:0] exp_frame(input bit wr, input logic [4:0] phy,
                                            input logic [4:0] rg, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), phy, rg,
            (wr ? 2'b10 : 2'b00), (wr ? d : 16'h0)};
  endfunction

  function automatic logic [31:0] mk_cmd(input logic [2:0] dv, input logic [4:0] phy,
                                         input logic [6:0] rg, input bit wr, input bit go);
    return {9'h0, dv, 3'h0, phy, 1'b0, rg, 2'b00, wr, go};
  endfunction

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  // walks negedges until busy clears, measuring MDC and MDIO behaviour
  task automatic measure(input int half, output int cyc, output int bad_runs,
                         output int hi_total, output int viol);
    logic [31:0] v;
    int run;
    logic pm, po, poe;
    cyc = 0; bad_runs = 0; hi_total = 0; viol = 0; run = 0;
    pm = 1'b0; po = mdio_o; poe = mdio_oe;
    forever begin
      if (mdc) begin
        run++; hi_total++;
        if (pm && ((mdio_o != po) || (mdio_oe != poe))) viol++;
      end else if (pm) begin
        if (run != half) bad_runs++;
        run = 0;
      end
      pm = mdc; po = mdio_o; poe = mdio_oe;
      reg_read(3'd0, v);
      if (!v[0]) break;
      cyc++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual 0x%0h expected 0x%0h", WATCHDOG, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, c;
    int cyc, bad, hi, viol, r;
    rst_n = 1'b0; bus_en = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    phy_val = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    reg_read(3'd0, v); check(v == 0, "R1 command after reset", v, 0);
    reg_read(3'd4, v); check(v == 0, "R1 data after reset", v, 0);
    check({mdc, mdio_oe, mdio_o} == 3'b000, "R1 pad idle", {mdc, mdio_oe, mdio_o}, 0);

    // R2 register map and field readback
    reg_write(3'd0, 32'hFF7A_B7F2);
    reg_read(3'd0, v); check(v == 32'h0070_B7F2, "R2 command readback", v, 32'h0070_B7F2);
    check(mdc == 1'b0, "R2 config write starts nothing", mdc, 0);
    reg_write(3'd4, 32'hDEAD_1234);
    reg_read(3'd4, v); check(v == 32'h0000_1234, "R2 data readback", v, 32'h1234);

    // R3 R4 R5 R6 R8: write frames over every divider code
    for (int code = 0; code < 8; code++) begin
      logic [15:0] d;
      logic [4:0]  phy;
      logic [6:0]  rg;
      d   = 16'h1234 ^ (16'(code) * 16'h1111);
      phy = 5'(code + 3);
      rg  = 7'h60 | 7'(code * 5);
      r   = exp_ratio(3'(code));
      reg_write(3'd4, {16'h0, d});
      reg_write(3'd0, mk_cmd(3'(code), phy, rg, 1'b1, 1'b1));
      measure(r / 2, cyc, bad, hi, viol);
      if (code >= 6) check(cyc == 64 * r, "R4 reserved code busy length", cyc, 64 * r);
      else           check(cyc == 64 * r, "R3 busy length", cyc, 64 * r);
      check(bad == 0, "R5 half-phase width", bad, 0);
      check(viol == 0, "R8 MDIO moved while MDC high", viol, 0);
      check(cap == exp_frame(1'b1, phy, rg[4:0], d), "R6 write frame bits",
            cap, exp_frame(1'b1, phy, rg[4:0], d));
      check(oecap == 64'hFFFF_FFFF_FFFF_FFFF, "R6 write enable", oecap, 64'hFFFF_FFFF_FFFF_FFFF);
      check(mdc == 1'b0, "R5 MDC low after frame", mdc, 0);
    end

    // R7 read frames with two data patterns
    for (int k = 0; k < 2; k++) begin
      logic [63:0] ef;
      phy_val = (k == 0) ? 16'hC3A5 : 16'h5A01;
      reg_write(3'd0, mk_cmd(3'd2, 5'h11 + 5'(k), 7'h0D, 1'b0, 1'b1));
      measure(8, cyc, bad, hi, viol);
      ef = exp_frame(1'b0, 5'h11 + 5'(k), 5'h0D, 16'h0);
      check(cyc == 1024, "R7 read busy length", cyc, 1024);
      check(cap[63:18] == ef[63:18], "R7 read header bits", cap[63:18], ef[63:18]);
      check(oecap == 64'hFFFF_FFFF_FFFC_0000, "R7 read enable pattern",
            oecap, 64'hFFFF_FFFF_FFFC_0000);
      reg_read(3'd4, v);
      check(v == {16'h0, phy_val}, "R7 read data", v, {16'h0, phy_val});
    end

    // R9 writes while busy are ignored
    reg_write(3'd4, 32'h0000_BEEF);
    c = mk_cmd(3'd2, 5'h01, 7'h02, 1'b1, 1'b1);
    reg_write(3'd0, c);
    reg_write(3'd4, 32'h0000_1111);
    reg_write(3'd0, mk_cmd(3'd0, 5'h1E, 7'h7F, 1'b0, 1'b1));
    measure(8, cyc, bad, hi, viol);
    check(cyc == 1020, "R9 busy length unchanged", cyc, 1020);
    reg_read(3'd4, v); check(v == 32'h0000_BEEF, "R9 data kept", v, 32'hBEEF);
    reg_read(3'd0, v); check(v == (c & 32'h0071_F7F2), "R9 command kept", v, c & 32'h0071_F7F2);
    check(cap[15:0] == 16'hBEEF, "R9 frame data intact", cap[15:0], 16'hBEEF);

    // R10 reset command wins over start, clears data
    reg_read(3'd4, v); check(v != 0, "R10 data nonzero before reset", v, 32'hBEEF);
    reg_write(3'd0, 32'h0000_0005);
    measure(8, cyc, bad, hi, viol);
    check(cyc == 4, "R10 reset busy length", cyc, 4);
    check(hi == 0, "R10 no MDC during reset", hi, 0);
    reg_read(3'd4, v); check(v == 0, "R10 data cleared", v, 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule